// File: doc/BRIEF.md
# Key-Locked Configuration Register Bank

This block is a small bank of chip-level configuration registers on a plain synchronous register bus. A handful of configuration words each sit behind their own lock register. Writing the matching key to a lock opens it for a short, fixed window. The data write has to land inside that window, and the lock then closes again without any further action. A second guard covers a shared configuration word and the Ethernet reset-control word: two kick registers must both hold their own keys before either word can be written.

Inside the shared configuration word, selected bits are set-only. Once enabled, they cannot be turned off again. The reset-control word holds one field per Ethernet port, and that port's reset output is asserted while any bit of its field is set. Protected writes that arrive while the guard is closed are dropped without a response, and they raise a sticky error flag. Reads are never blocked.

The bus is a register interface, not a data stream, so it has no valid/ready handshake. A write takes effect at the rising edge where `we` is high. Read data is registered and appears on `rdata` after the rising edge where `re` is high, then holds until the next read.

Top module: `keylock_cfg_bank`

The word addresses are as follows:
- Addresses 0 to 3 are configuration words 0 to 3.
- Addresses 4 to 7 are the locks for those words.
- Addresses 8 and 9 are the two kick registers.
- Address 10 is the shared configuration word.
- Address 11 is the reset-control word.
- Address 12 is the status word, with the error flag in bit 0.

## Requirements
- R1: Configuration word i (address i) accepts a write only while lock i is open. Otherwise the word keeps its value.
- R2: Writing key `LOCK_KEY_BASE + i` to lock i (address 4+i) at edge k opens the lock. Writes at edges k+1 through k+`RELOCK_CYC` are accepted, and from edge k+`RELOCK_CYC`+1 onwards writes are dropped.
- R3: Writing zero, or any value other than its key, to a lock register closes that lock at once.
- R4: The shared word (address 10) and the reset-control word (address 11) are writable only while kick register 0 (address 8) holds `KICK_KEY0` and kick register 1 (address 9) holds `KICK_KEY1`. Writing any other value, zero included, to either kick register re-protects both words.
- R5: Bits of the shared word that are set in `EO_MASK` can only be set. A write whose value has such a bit at 0 leaves that bit unchanged. The other bits take the written value.
- R6: `port_rst_o[p]` is 1 exactly while any bit in field p of the reset-control word is 1. Field p is bits [p*`RST_W` +: `RST_W`].
- R7: A write to a protected word while its guard is closed sets `err_o`. The flag stays set until a write to status (address 12) with bit 0 = 1.
- R8: Reads are always allowed. A lock or kick register reads back 1 while it is open and 0 while it is closed, and never returns the key. Status reads return `err_o` in bit 0.
- R9: After reset, all configuration words and the reset-control word are zero, all locks and kick registers are closed, and `err_o` is 0.
- R10: Writes to unmapped addresses (13 to 15) change nothing, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Word address |
| wdata | input | DW | Write data |
| we | input | 1 | Write enable |
| re | input | 1 | Read enable |
| rdata | output | DW | Registered read data |
| cfg_o | output | N_LOCK*DW | Lock-protected configuration words, word i at [i*DW +: DW] |
| guard_o | output | DW | Kick-protected shared configuration word |
| port_rst_o | output | N_PORTS | Per-port Ethernet reset outputs |
| err_o | output | 1 | Sticky dropped-write flag |

## Verification
The bench builds the bank with `RELOCK_CYC` = 3, so the last accepted cycle of the window and the first dropped cycle each fall only a few idle cycles after the key write. It uses `EO_MASK` = 0xF0, which puts set-only bits and ordinary bits side by side in one byte, so a single clearing write shows both behaviours at once. With two ports of four bits each, one reset-control write can assert one port's reset while the other port stays released.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  localparam int ADDR_W      = 4;
  localparam int MAX_LOCKS   = 4;
  localparam int CFG_BASE    = 0;
  localparam int LOCK_BASE   = 4;
  localparam int KICK_BASE   = 8;
  localparam int GUARD_ADDR  = 10;
  localparam int RSTCTL_ADDR = 11;
  localparam int STATUS_ADDR = 12;

  typedef enum logic [1:0] {
    GATE_NONE  = 2'd0,
    GATE_LOCK  = 2'd1,
    GATE_KICK  = 2'd2
  } gate_kind_e;
endpackage

// File: rtl/lock_slot.sv
module lock_slot #(
  parameter int RELOCK_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_wr,
  input  logic key_hit,
  output logic open_o
);
  localparam int CW = $clog2(RELOCK_CYC + 1);

  logic [CW-1:0] win_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
    end else if (key_wr) begin
      win_cnt <= key_hit ? CW'(RELOCK_CYC) : '0;
    end else if (win_cnt != '0) begin
      win_cnt <= win_cnt - 1'b1;
    end
  end

  assign open_o = (win_cnt != '0);

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= CW'(RELOCK_CYC)); // R2
  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_hit) |=> open_o); // R2
  AST_MISS_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !key_hit) |=> !open_o); // R3
endmodule

// File: rtl/kick_pair.sv
module kick_pair #(
  parameter int DW = 32,
  parameter logic [DW-1:0] KEY0 = '0,
  parameter logic [DW-1:0] KEY1 = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    kick_wr,
  input  logic [DW-1:0] wdata,
  output logic [1:0]    held_o,
  output logic          open_o
);
  logic [1:0] held_q;
  logic [1:0] hit;

  assign hit[0] = (wdata == KEY0);
  assign hit[1] = (wdata == KEY1);

  for (genvar j = 0; j < 2; j++) begin : g_kick
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          held_q[j] <= 1'b0;
      else if (kick_wr[j]) held_q[j] <= hit[j];
    end
  end

  assign held_o = held_q;
  assign open_o = &held_q;

  AST_KICK_MISS_PROTECTS: assert property (@(posedge clk) disable iff (!rst_n)
    ((kick_wr[0] && !hit[0]) || (kick_wr[1] && !hit[1])) |=> !open_o); // R4
  AST_KICK_ONEHOT_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(kick_wr)); // R4
endmodule

// File: rtl/keylock_cfg_bank.sv
module keylock_cfg_bank
  import keylock_pkg::*;
#(
  parameter int DW         = 32,
  parameter int N_LOCK     = 4,
  parameter int RELOCK_CYC = 4,
  parameter int N_PORTS    = 2,
  parameter int RST_W      = 4,
  parameter logic [DW-1:0] LOCK_KEY_BASE = 32'h5A5A_C300,
  parameter logic [DW-1:0] KICK_KEY0     = 32'h83E7_0B13,
  parameter logic [DW-1:0] KICK_KEY1     = 32'h95A4_F1E0,
  parameter logic [DW-1:0] EO_MASK       = 32'h0000_00FF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DW-1:0]        wdata,
  input  logic                 we,
  input  logic                 re,
  output logic [DW-1:0]        rdata,
  output logic [N_LOCK*DW-1:0] cfg_o,
  output logic [DW-1:0]        guard_o,
  output logic [N_PORTS-1:0]   port_rst_o,
  output logic                 err_o
);
  localparam int LOCKS_USED = (N_LOCK < MAX_LOCKS) ? N_LOCK : MAX_LOCKS;

  logic [LOCKS_USED-1:0] lock_open;
  logic [LOCKS_USED-1:0] cfg_hit;
  logic [DW-1:0]         cfg_q [LOCKS_USED];
  logic [1:0]            kick_held;
  logic                  kick_open;
  logic [DW-1:0]         guard_q;
  logic [DW-1:0]         rstctl_q;
  logic                  err_q;
  logic                  guard_hit, rstctl_hit, status_hit;
  logic                  drop_wr;
  logic [DW-1:0]         rd_mux;

  // ---------------- lock-protected configuration words ----------------
  for (genvar i = 0; i < LOCKS_USED; i++) begin : g_lock
    logic lock_wr_i;
    assign lock_wr_i  = we && (addr == ADDR_W'(LOCK_BASE + i));
    assign cfg_hit[i] = we && (addr == ADDR_W'(CFG_BASE + i));

    lock_slot #(.RELOCK_CYC(RELOCK_CYC)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .key_wr (lock_wr_i),
      .key_hit(wdata == (LOCK_KEY_BASE + DW'(i))),
      .open_o (lock_open[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cfg_q[i] <= '0;
      else if (cfg_hit[i] && lock_open[i]) cfg_q[i] <= wdata;
    end

    assign cfg_o[i*DW +: DW] = cfg_q[i];

    AST_CFG_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hit[i] && !lock_open[i]) |=> $stable(cfg_q[i])); // R1
    AST_CFG_LOCKED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hit[i] && !lock_open[i]) |=> err_q); // R7
  end

  if (LOCKS_USED < N_LOCK) begin : g_pad
    assign cfg_o[N_LOCK*DW-1:LOCKS_USED*DW] = '0;
  end

  // ---------------- kick-protected words ----------------
  kick_pair #(.DW(DW), .KEY0(KICK_KEY0), .KEY1(KICK_KEY1)) u_kick (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick_wr({we && (addr == ADDR_W'(KICK_BASE + 1)),
              we && (addr == ADDR_W'(KICK_BASE))}),
    .wdata  (wdata),
    .held_o (kick_held),
    .open_o (kick_open)
  );

  assign guard_hit  = we && (addr == ADDR_W'(GUARD_ADDR));
  assign rstctl_hit = we && (addr == ADDR_W'(RSTCTL_ADDR));
  assign status_hit = we && (addr == ADDR_W'(STATUS_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guard_q  <= '0;
      rstctl_q <= '0;
    end else if (kick_open) begin
      if (guard_hit)
        guard_q <= (wdata & ~EO_MASK) | ((guard_q | wdata) & EO_MASK);
      if (rstctl_hit)
        rstctl_q <= wdata;
    end
  end

  assign guard_o = guard_q;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign port_rst_o[p] = |rstctl_q[p*RST_W +: RST_W];
  end

  // ---------------- sticky error ----------------
  assign drop_wr = (|(cfg_hit & ~lock_open)) ||
                   ((guard_hit || rstctl_hit) && !kick_open);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      err_q <= 1'b0;
    else if (drop_wr)                err_q <= 1'b1;
    else if (status_hit && wdata[0]) err_q <= 1'b0;
  end

  assign err_o = err_q;

  // ---------------- read path ----------------
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < LOCKS_USED; i++) begin
      if (addr == ADDR_W'(CFG_BASE + i))  rd_mux = cfg_q[i];
      if (addr == ADDR_W'(LOCK_BASE + i)) rd_mux = DW'(lock_open[i]);
    end
    if (addr == ADDR_W'(KICK_BASE))     rd_mux = DW'(kick_held[0]);
    if (addr == ADDR_W'(KICK_BASE + 1)) rd_mux = DW'(kick_held[1]);
    if (addr == ADDR_W'(GUARD_ADDR))    rd_mux = guard_q;
    if (addr == ADDR_W'(RSTCTL_ADDR))   rd_mux = rstctl_q;
    if (addr == ADDR_W'(STATUS_ADDR))   rd_mux = DW'(err_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= rd_mux;
  end

  // ---------------- assertions ----------------
  AST_EO_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(guard_q) & EO_MASK & ~guard_q) == '0)); // R5
  AST_GUARD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_hit && !kick_open) |=> $stable(guard_q)); // R4
  AST_RSTCTL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rstctl_hit && !kick_open) |=> $stable(port_rst_o)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(status_hit && wdata[0])) |=> err_q); // R7
  AST_LOCK_READ_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (re && (addr >= ADDR_W'(LOCK_BASE)) && (addr <= ADDR_W'(KICK_BASE + 1)))
      |=> (rdata[DW-1:1] == '0)); // R8
endmodule

// File: tb/keylock_cfg_bank_tb_top.sv
module keylock_cfg_bank_tb_top;
  localparam int DW = 32;
  localparam int N_LOCK = 4;
  localparam int RELOCK = 3;
  localparam logic [31:0] LKB = 32'h5A5A_C300;
  localparam logic [31:0] KK0 = 32'h83E7_0B13;
  localparam logic [31:0] KK1 = 32'h95A4_F1E0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic we = 1'b0, re = 1'b0;
  logic [DW-1:0] rdata;
  logic [N_LOCK*DW-1:0] cfg_o;
  logic [DW-1:0] guard_o;
  logic [1:0] port_rst_o;
  logic err_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  keylock_cfg_bank #(
    .DW(DW), .N_LOCK(N_LOCK), .RELOCK_CYC(RELOCK), .N_PORTS(2), .RST_W(4),
    .LOCK_KEY_BASE(LKB), .KICK_KEY0(KK0), .KICK_KEY1(KK1),
    .EO_MASK(32'h0000_00F0)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .rdata(rdata), .cfg_o(cfg_o), .guard_o(guard_o), .port_rst_o(port_rst_o),
    .err_o(err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_err();
    wr(4'd12, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R9 cfg", 32'(|cfg_o), 32'h0);
    check("R9 guard", guard_o, 32'h0);
    check("R9 port_rst", 32'(port_rst_o), 32'h0);
    check("R9 err", 32'(err_o), 32'h0);
    rd(4'd4, d); check("R9 lock0 closed", d, 32'h0);
  endtask

  task automatic t_no_key();
    wr(4'd0, 32'hDEAD_0001);
    check("R1 locked write dropped", cfg_o[31:0], 32'h0);
    check("R7 err set", 32'(err_o), 32'h1);
    idle(2);
    check("R7 err sticky", 32'(err_o), 32'h1);
    clear_err();
    check("R7 err cleared", 32'(err_o), 32'h0);
  endtask

  task automatic t_window();
    logic [31:0] d;
    wr(4'd5, LKB + 32'd1);
    wr(4'd1, 32'h1111_AAAA);
    check("R1 unlocked write", cfg_o[63:32], 32'h1111_AAAA);
    rd(4'd5, d); check("R8 lock reads 1", d, 32'h1);
    wr(4'd5, LKB + 32'd1);
    idle(2);
    wr(4'd1, 32'h2222_BBBB);
    check("R2 last window edge", cfg_o[63:32], 32'h2222_BBBB);
    check("R2 no err", 32'(err_o), 32'h0);
    wr(4'd5, LKB + 32'd1);
    idle(3);
    wr(4'd1, 32'h3333_CCCC);
    check("R2 after window", cfg_o[63:32], 32'h2222_BBBB);
    check("R7 err after window", 32'(err_o), 32'h1);
    rd(4'd5, d); check("R8 lock reads 0", d, 32'h0);
    clear_err();
  endtask

  task automatic t_wrong_key();
    wr(4'd6, LKB + 32'd3);
    wr(4'd2, 32'h4444_0000);
    check("R3 wrong key", cfg_o[95:64], 32'h0);
    clear_err();
    wr(4'd7, LKB + 32'd3);
    wr(4'd7, 32'h0);
    wr(4'd3, 32'h5555_0000);
    check("R3 zero relock", cfg_o[127:96], 32'h0);
    check("R3 err", 32'(err_o), 32'h1);
    clear_err();
  endtask

  task automatic t_kick();
    logic [31:0] d;
    wr(4'd8, KK0);
    wr(4'd10, 32'h0000_0003);
    check("R4 one kick only", guard_o, 32'h0);
    clear_err();
    wr(4'd9, KK1);
    rd(4'd9, d); check("R8 kick reads 1", d, 32'h1);
    wr(4'd10, 32'h0000_0003);
    check("R4 both kicks", guard_o, 32'h3);
    wr(4'd11, 32'h0000_00F0);
    check("R6 port1 only", 32'(port_rst_o), 32'h2);
    wr(4'd11, 32'h0000_0001);
    check("R6 port0 only", 32'(port_rst_o), 32'h1);
    wr(4'd11, 32'h0);
    check("R6 released", 32'(port_rst_o), 32'h0);
    wr(4'd10, 32'h0000_00FF);
    wr(4'd10, 32'h0000_0000);
    check("R5 set-only bits kept", guard_o, 32'h0000_00F0);
    wr(4'd9, 32'h0);
    wr(4'd11, 32'h0000_000F);
    check("R4 zero kick protects", 32'(port_rst_o), 32'h0);
    check("R7 kick drop err", 32'(err_o), 32'h1);
    clear_err();
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(4'd13, 32'hFFFF_FFFF);
    rd(4'd13, d); check("R10 unmapped read", d, 32'h0);
    check("R10 cfg untouched", cfg_o[63:32], 32'h2222_BBBB);
    check("R10 no err", 32'(err_o), 32'h0);
    rd(4'd12, d); check("R8 status read", d, 32'h0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_no_key();
    t_window();
    t_wrong_key();
    t_kick();
    t_unmapped();
    done = 1'b1;
    finish_run();
  end
endmodule